// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This unit carries out the byte operations reached through the extended opcode prefix of an 8-bit processor. It rotates left or right, either circularly or through the carry flag. It performs arithmetic left and right shifts and a logical right shift. It swaps the two nibbles of a byte. It also tests, sets or clears a single selected bit. The opcode prefix is decoded outside the unit, which receives an operation kind, an operand-source mode, a bit index, the operand byte and the current flag nibble.

Operands arrive on one of three paths. A register operand gives its result one cycle after it is accepted. A memory operand uses a read-modify-write sequence. In the first phase, the unit reports busy and captures the byte that the memory returns for the HL address. In the second phase, it drives the modified byte together with a write strobe and updates the flags. A short accumulator form covers the four rotates only, and in that form the zero flag is always cleared. The flag nibble uses the same layout as the ALU: Z at bit 3, N at bit 2, H at bit 1 and C at bit 0.

Top module: `rsb_unit`

## Requirements
- R1: Kind 0 (rotate left circular) sends bit 7 to both C and result bit 0. Kind 1 (rotate right circular) sends bit 0 to both C and result bit 7.
- R2: Kind 2 (rotate left through carry) puts the incoming C into result bit 0 and sends bit 7 to C. Kind 3 (rotate right through carry) puts the incoming C into result bit 7 and sends bit 0 to C.
- R3: Kind 4 shifts left, fills bit 0 with 0 and sends bit 7 to C. Kind 5 shifts right, keeps bit 7 and sends bit 0 to C. Kind 6 shifts right, fills bit 7 with 0 and sends bit 0 to C.
- R4: Kind 7 exchanges the upper and lower nibbles, clears N, H and C, and sets Z only when the result is zero.
- R5: For kinds 0 to 6, N and H are cleared and Z is set exactly when the result is zero. The flag nibble is {Z,N,H,C} from bit 3 down to bit 0.
- R6: In accumulator mode (mode 2), kinds 0 to 3 clear Z whatever the result. All other kinds in mode 2 behave as in register mode (mode 0; mode 3 is treated as mode 0 too).
- R7: Kind 8 (bit test) sets Z when the selected bit is 0, sets H, clears N, preserves C, and returns the operand unchanged.
- R8: Kind 9 sets and kind 10 clears only the selected bit. The flag nibble passes through unchanged.
- R9: A register or accumulator operation accepted in one cycle raises done for exactly one cycle in the next cycle, with result and flags valid and no write strobe. After reset, all outputs are 0.
- R10: A memory operation (mode 1) raises busy for the one cycle after acceptance and samples mem_rdata in that cycle. In the following cycle it raises done and mem_we, with result holding the byte to write back and flags updated.
- R11: Bit test on a memory operand raises done with updated flags but never mem_we.
- R12: An op_valid seen while busy is high is ignored and changes no output.
- R13: Kinds 11 to 15 return the operand unchanged and leave the flag nibble unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Start an operation this cycle (ignored while busy) |
| op_kind | input | 4 | Operation kind, codes as in R1 to R13 |
| op_mode | input | 2 | 0 register, 1 memory, 2 accumulator, 3 as register |
| op_bit | input | 3 | Bit index for kinds 8 to 10 |
| op_data | input | 8 | Register or accumulator operand |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| mem_rdata | input | 8 | Byte read at the HL address, sampled while busy |
| busy | output | 1 | Memory phase 1 in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | 8 | Result byte, also the write-back data |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| mem_we | output | 1 | Write strobe for the memory write-back (phase 2) |

## Verification
The unit can finish the write-back phase of a memory operation in the same cycle that it accepts a new register or memory operation. The bench provokes this by issuing a new op_valid in the cycle where mem_we is high. It then checks that this cycle still writes the earlier result, and that the new operation's result, or its busy phase, shows up in the next cycle. The bench also raises op_valid during the busy cycle, and the cycle-level reference model expects that request to be dropped.

// File: rtl/rsb_pkg.sv
`timescale 1ns/1ps
package rsb_pkg;

    typedef enum logic [3:0] {
        K_RLC  = 4'd0,
        K_RRC  = 4'd1,
        K_RL   = 4'd2,
        K_RR   = 4'd3,
        K_SLA  = 4'd4,
        K_SRA  = 4'd5,
        K_SRL  = 4'd6,
        K_SWAP = 4'd7,
        K_BIT  = 4'd8,
        K_SET  = 4'd9,
        K_RES  = 4'd10,
        K_R11  = 4'd11,
        K_R12  = 4'd12,
        K_R13  = 4'd13,
        K_R14  = 4'd14,
        K_R15  = 4'd15
    } rsb_kind_e;

    typedef enum logic [1:0] {
        M_REG = 2'd0,
        M_MEM = 2'd1,
        M_ACC = 2'd2,
        M_ALT = 2'd3
    } rsb_mode_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_FETCH = 1'b1
    } rsb_phase_e;

    localparam int FLG_Z = 3;
    localparam int FLG_N = 2;
    localparam int FLG_H = 1;
    localparam int FLG_C = 0;

endpackage

// File: rtl/rsb_shifter.sv
`timescale 1ns/1ps
module rsb_shifter
    import rsb_pkg::*;
#(
    parameter int DW = 8
) (
    input  rsb_kind_e         kind,
    input  logic              acc_form,
    input  logic              cin,
    input  logic [DW-1:0]     x,
    output logic [DW-1:0]     res,
    output logic [3:0]        flg
);
    localparam int HALF = DW / 2;

    logic cout;
    logic is_rot;
    logic zf;

    always_comb begin
        res  = x;
        cout = 1'b0;
        case (kind)
            K_RLC:  begin res = {x[DW-2:0], x[DW-1]};  cout = x[DW-1]; end
            K_RRC:  begin res = {x[0], x[DW-1:1]};     cout = x[0];    end
            K_RL:   begin res = {x[DW-2:0], cin};      cout = x[DW-1]; end
            K_RR:   begin res = {cin, x[DW-1:1]};      cout = x[0];    end
            K_SLA:  begin res = {x[DW-2:0], 1'b0};     cout = x[DW-1]; end
            K_SRA:  begin res = {x[DW-1], x[DW-1:1]};  cout = x[0];    end
            K_SRL:  begin res = {1'b0, x[DW-1:1]};     cout = x[0];    end
            K_SWAP: begin res = {x[HALF-1:0], x[DW-1:HALF]}; cout = 1'b0; end
            default: begin res = x; cout = 1'b0; end
        endcase
    end

    assign is_rot = (kind == K_RLC) || (kind == K_RRC) || (kind == K_RL) || (kind == K_RR);
    assign zf     = ~|res & ~(acc_form & is_rot);

    always_comb begin
        flg        = 4'b0000;
        flg[FLG_Z] = zf;
        flg[FLG_C] = cout;
    end

endmodule

// File: rtl/rsb_bitfield.sv
`timescale 1ns/1ps
module rsb_bitfield
    import rsb_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  rsb_kind_e         kind,
    input  logic [BW-1:0]     idx,
    input  logic [DW-1:0]     x,
    input  logic [3:0]        fin,
    output logic [DW-1:0]     res,
    output logic [3:0]        flg
);
    logic [DW-1:0] mask;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (idx == BW'(i));
    end

    always_comb begin
        res = x;
        flg = fin;
        case (kind)
            K_BIT: begin
                res        = x;
                flg[FLG_Z] = ~|(x & mask);
                flg[FLG_N] = 1'b0;
                flg[FLG_H] = 1'b1;
                flg[FLG_C] = fin[FLG_C];
            end
            K_SET: res = x | mask;
            K_RES: res = x & ~mask;
            default: begin
                res = x;
                flg = fin;
            end
        endcase
    end

endmodule

// File: rtl/rsb_unit.sv
`timescale 1ns/1ps
module rsb_unit
    import rsb_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_kind,
    input  logic [1:0]        op_mode,
    input  logic [BW-1:0]     op_bit,
    input  logic [DW-1:0]     op_data,
    input  logic [3:0]        flags_in,
    input  logic [DW-1:0]     mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     result,
    output logic [3:0]        flags_out,
    output logic              mem_we
);

    typedef struct packed {
        rsb_phase_e     ph;
        rsb_kind_e      kind;
        logic [BW-1:0]  bidx;
        logic [3:0]     fin;
        logic [DW-1:0]  res;
        logic [3:0]     flg;
        logic           done;
        logic           we;
    } st_t;

    st_t st_d, st_q;

    rsb_kind_e      c_kind;
    logic [BW-1:0]  c_bit;
    logic [DW-1:0]  c_x;
    logic [3:0]     c_fin;
    logic           c_acc;
    logic [DW-1:0]  sh_res, bf_res, c_res;
    logic [3:0]     sh_flg, bf_flg, c_flg;

    always_comb begin
        if (st_q.ph == PH_FETCH) begin
            c_kind = st_q.kind;
            c_bit  = st_q.bidx;
            c_x    = mem_rdata;
            c_fin  = st_q.fin;
            c_acc  = 1'b0;
        end else begin
            c_kind = rsb_kind_e'(op_kind);
            c_bit  = op_bit;
            c_x    = op_data;
            c_fin  = flags_in;
            c_acc  = (rsb_mode_e'(op_mode) == M_ACC);
        end
    end

    rsb_shifter #(.DW(DW)) u_shift (
        .kind     (c_kind),
        .acc_form (c_acc),
        .cin      (c_fin[FLG_C]),
        .x        (c_x),
        .res      (sh_res),
        .flg      (sh_flg)
    );

    rsb_bitfield #(.DW(DW)) u_bits (
        .kind (c_kind),
        .idx  (c_bit),
        .x    (c_x),
        .fin  (c_fin),
        .res  (bf_res),
        .flg  (bf_flg)
    );

    assign c_res = (c_kind < K_BIT) ? sh_res : bf_res;
    assign c_flg = (c_kind < K_BIT) ? sh_flg : bf_flg;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = 1'b0;
        case (st_q.ph)
            PH_FETCH: begin
                st_d.res  = c_res;
                st_d.flg  = c_flg;
                st_d.done = 1'b1;
                st_d.we   = (st_q.kind != K_BIT);
                st_d.ph   = PH_IDLE;
            end
            default: begin
                if (op_valid) begin
                    if (rsb_mode_e'(op_mode) == M_MEM) begin
                        st_d.ph   = PH_FETCH;
                        st_d.kind = rsb_kind_e'(op_kind);
                        st_d.bidx = op_bit;
                        st_d.fin  = flags_in;
                    end else begin
                        st_d.res  = c_res;
                        st_d.flg  = c_flg;
                        st_d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, kind: K_RLC, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.ph == PH_FETCH);
    assign done      = st_q.done;
    assign result    = st_q.res;
    assign flags_out = st_q.flg;
    assign mem_we    = st_q.we;

endmodule

// File: rtl/rsb_unit_chk.sv
`timescale 1ns/1ps
module rsb_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_kind,
    input logic [1:0] op_mode,
    input logic [3:0] flags_in,
    input logic       busy,
    input logic       done,
    input logic       mem_we,
    input logic [3:0] flags_out
);
    logic reg_start;
    assign reg_start = op_valid && !busy && (op_mode != 2'd1);

    p_busy_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_busy_then_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> done);

    p_we_after_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(busy));

    p_we_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> done);

    p_reg_one_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_start |=> (done && !mem_we && !busy));

    p_shift_nh_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_start && op_kind < 4'd8) |=> (flags_out[2:1] == 2'b00));

    p_setres_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_start && (op_kind == 4'd9 || op_kind == 4'd10)) |=> (flags_out == $past(flags_in)));

    p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid) |=> (!busy && done));

endmodule

bind rsb_unit rsb_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .op_mode   (op_mode),
    .flags_in  (flags_in),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .flags_out (flags_out)
);

// File: tb/sim_rsb_unit.sv
`timescale 1ns/1ps
module sim_rsb_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_kind = '0;
    logic [1:0] op_mode = '0;
    logic [2:0] op_bit = '0;
    logic [7:0] op_data = '0;
    logic [3:0] flags_in = '0;
    logic [7:0] mem_rdata = '0;
    logic       busy, done, mem_we;
    logic [7:0] result;
    logic [3:0] flags_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit        m_pend = 0;
    int        m_kind = 0;
    int        m_bit = 0;
    logic [3:0] m_fin = '0;
    string     m_ptag = "R10";
    bit        e_busy = 0, e_done = 0, e_we = 0;
    logic [7:0] e_res = '0;
    logic [3:0] e_flg = '0;
    string     e_tag = "R9";

    always #10 clk = ~clk;

    rsb_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_mode(op_mode), .op_bit(op_bit), .op_data(op_data),
        .flags_in(flags_in), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .result(result), .flags_out(flags_out), .mem_we(mem_we)
    );

    function automatic logic [11:0] ref_calc(int k, bit acc, int b, logic [7:0] x, logic [3:0] f);
        logic [7:0] r;
        logic [3:0] fo;
        bit c;
        r = x; c = 0; fo = f;
        if (k <= 7) begin
            case (k)
                0: begin c = x[7]; r = (x << 1) | (x >> 7); end
                1: begin c = x[0]; r = (x >> 1) | (x << 7); end
                2: begin c = x[7]; r = (x << 1) | 8'(f[0]); end
                3: begin c = x[0]; r = (x >> 1) | (f[0] ? 8'h80 : 8'h00); end
                4: begin c = x[7]; r = x << 1; end
                5: begin c = x[0]; r = (x >> 1) | (x & 8'h80); end
                6: begin c = x[0]; r = x >> 1; end
                default: begin c = 0; r = {x[3:0], x[7:4]}; end
            endcase
            fo = {(r == 0) && !(acc && k < 4), 1'b0, 1'b0, c};
        end else if (k == 8) begin
            fo = {!x[b], 1'b0, 1'b1, f[0]};
        end else if (k == 9) begin
            r = x | (8'h01 << b);
        end else if (k == 10) begin
            r = x & ~(8'h01 << b);
        end
        return {r, fo};
    endfunction

    task automatic chk(string what, int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: compare, then drive, then advance the model
    task automatic cyc(bit v, int k, int md, int b, logic [7:0] d, logic [3:0] f,
                       logic [7:0] rd, string tag);
        logic [11:0] rr;
        @(negedge clk);
        chk("busy", busy, e_busy, e_tag);
        chk("done", done, e_done, e_tag);
        chk("mem_we", mem_we, e_we, e_tag);
        chk("result", result, e_res, e_tag);
        chk("flags", flags_out, e_flg, e_tag);
        op_valid = v; op_kind = 4'(k); op_mode = 2'(md); op_bit = 3'(b);
        op_data = d; flags_in = f; mem_rdata = rd;
        e_done = 0; e_we = 0;
        if (m_pend) begin
            rr = ref_calc(m_kind, 0, m_bit, rd, m_fin);
            e_res = rr[11:4]; e_flg = rr[3:0];
            e_done = 1; e_we = (m_kind != 8);
            m_pend = 0; e_busy = 0; e_tag = m_ptag;
        end else if (v) begin
            if (md == 1) begin
                m_pend = 1; m_kind = k; m_bit = b; m_fin = f; m_ptag = tag;
                e_busy = 1; e_tag = tag;
            end else begin
                rr = ref_calc(k, md == 2, b, d, f);
                e_res = rr[11:4]; e_flg = rr[3:0];
                e_done = 1; e_tag = tag;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00, 4'h0, 8'h00, e_tag);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // reset state R9
        idle(1);
        // R1
        cyc(1, 0, 0, 0, 8'h85, 4'h0, 8'h00, "R1");
        cyc(1, 0, 0, 0, 8'h00, 4'h1, 8'h00, "R1");
        cyc(1, 1, 0, 0, 8'h01, 4'h0, 8'h00, "R1");
        cyc(1, 1, 0, 0, 8'h7E, 4'h1, 8'h00, "R1");
        // R2
        cyc(1, 2, 0, 0, 8'h80, 4'h0, 8'h00, "R2");
        cyc(1, 2, 0, 0, 8'h11, 4'h1, 8'h00, "R2");
        cyc(1, 3, 0, 0, 8'h01, 4'h1, 8'h00, "R2");
        cyc(1, 3, 0, 0, 8'h02, 4'h0, 8'h00, "R2");
        // R3
        cyc(1, 4, 0, 0, 8'hFF, 4'h0, 8'h00, "R3");
        cyc(1, 5, 0, 0, 8'h81, 4'h0, 8'h00, "R3");
        cyc(1, 6, 0, 0, 8'h01, 4'h0, 8'h00, "R3");
        cyc(1, 6, 0, 0, 8'h80, 4'hF, 8'h00, "R3");
        // R4
        cyc(1, 7, 0, 0, 8'hF0, 4'hF, 8'h00, "R4");
        cyc(1, 7, 0, 0, 8'h00, 4'h7, 8'h00, "R4");
        // R5: incoming N and H set
        cyc(1, 0, 0, 0, 8'h40, 4'h6, 8'h00, "R5");
        cyc(1, 5, 0, 0, 8'h00, 4'hE, 8'h00, "R5");
        // R6
        cyc(1, 0, 2, 0, 8'h80, 4'h0, 8'h00, "R6");
        cyc(1, 2, 2, 0, 8'h80, 4'h0, 8'h00, "R6");
        cyc(1, 1, 2, 0, 8'h00, 4'h8, 8'h00, "R6");
        cyc(1, 3, 2, 0, 8'h01, 4'h0, 8'h00, "R6");
        cyc(1, 4, 2, 0, 8'h80, 4'h0, 8'h00, "R6");
        cyc(1, 8, 2, 2, 8'h00, 4'h0, 8'h00, "R6");
        // R7
        cyc(1, 8, 0, 7, 8'h7F, 4'h1, 8'h00, "R7");
        cyc(1, 8, 0, 0, 8'h01, 4'h4, 8'h00, "R7");
        cyc(1, 8, 3, 5, 8'hDF, 4'h0, 8'h00, "R7");
        // R8
        cyc(1, 9, 0, 3, 8'h00, 4'hA, 8'h00, "R8");
        cyc(1, 10, 0, 7, 8'hFF, 4'h5, 8'h00, "R8");
        cyc(1, 9, 0, 0, 8'h01, 4'h3, 8'h00, "R8");
        // R13
        cyc(1, 12, 0, 1, 8'h5A, 4'h9, 8'h00, "R13");
        cyc(1, 15, 0, 6, 8'hA5, 4'h6, 8'h00, "R13");
        idle(2);
        // R10 memory rotate, then R12 op_valid while busy
        cyc(1, 3, 1, 0, 8'h00, 4'h1, 8'hFF, "R10");
        cyc(1, 0, 0, 0, 8'h55, 4'h0, 8'h02, "R12");
        idle(1);
        // memory write-back overlapping a new register op
        cyc(1, 10, 1, 4, 8'h00, 4'hC, 8'h00, "R10");
        cyc(0, 0, 0, 0, 8'h00, 4'h0, 8'hFF, "R10");
        cyc(1, 0, 0, 0, 8'h81, 4'h0, 8'h00, "R9");
        idle(1);
        // R11 memory bit test, back to back with a memory swap
        cyc(1, 8, 1, 6, 8'h00, 4'h1, 8'h00, "R11");
        cyc(0, 0, 0, 0, 8'h00, 4'h0, 8'h40, "R11");
        cyc(1, 7, 1, 0, 8'h00, 4'h0, 8'h00, "R10");
        cyc(0, 0, 0, 0, 8'h00, 4'h0, 8'h3C, "R10");
        cyc(1, 8, 1, 3, 8'h00, 4'h0, 8'h00, "R11");
        cyc(0, 0, 0, 0, 8'h00, 4'h0, 8'h00, "R11");
        idle(2);
        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                8'($urandom), 4'($urandom), 8'($urandom), "R10");
        end
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule